// File: doc/BRIEF.md
# Timer Match and PWM Output Unit

This block is a free-running 16-bit timer that drives four output pins. Each pin has its own compare value. A fifth value sets the length of one timer cycle. Each channel works in one of two ways:

- **Match-action output.** A stored output bit is set, cleared, toggled or left alone each time the count equals the channel's compare value.
- **Single-edge PWM output.** The pin level comes straight from comparing the count against the compare value. The comparison depends on the counting direction, and there are two extra settings that force the level low or high.

The count runs upward and wraps to zero after the period value, or runs downward and reloads the period value after zero. A select bit per pin hands the pin back to a general-purpose I/O path. The per-channel settings live in one control word that only accepts a write carrying a fixed key byte. Compare values, the period and the match actions are plain inputs, driven by whatever register file surrounds the block.

Top module: `tpw_unit`

## Requirements
- R1: On a cycle with `rst` high, the following clear at the next edge: the count, every control field and every stored match-action bit. With all pin selects at 0, each pin follows `gpio_i`.
- R2: With `count_down` low and `run` high, the count steps 0, 1, …, `period` and then returns to 0. With `run` low, the count holds its value.
- R3: With `count_down` high and `run` high, the count decrements by one each cycle. A count of 0, or a count above `period`, is replaced by `period` on the next cycle. The first step after reset therefore goes from 0 to `period`.
- R4: A control write is applied only when `cfg_wdata[31:24]` equals 8'h5A. With any other key byte, the whole write leaves `cfg_rdata` and every pin unchanged.
- R5: `cfg_rdata` places the following fields:
  - bits 31:24 and bits 19:12 always read 0, and writes to bits 19:12 are dropped;
  - bit 20+n is the pin select of channel n;
  - bits 2n+5:2n+4 are the output mode of channel n;
  - bit n is the PWM enable of channel n.
- R6: When the pin select of channel n is 0, `pin_o[n]` equals `gpio_i[n]`. When it is 1, `pin_o[n]` carries the channel's output.
- R7: PWM output mode 00 gives 0 while count < compare value when counting up, and 0 while count ≤ compare value when counting down. It gives 1 otherwise. The output follows the count in the same cycle.
- R8: PWM output mode 01 gives the inverse of mode 00 for the same count, compare value and direction.
- R9: PWM output mode 10 holds the output at 0, and mode 11 holds it at 1, whatever the count.
- R10: The match action of channel n is `act_cfg[2n+1:2n]`: 00 keep, 01 clear, 10 set, 11 toggle. It is applied on each edge where `run` is high and the count equals that channel's compare value. The result is seen on the pin from the next cycle whenever the PWM enable is 0.
- R11: A compare value above `period` never produces a match event in either direction, and in mode 00 it holds the PWM output at 0. A compare value equal to `period` is reached once per cycle. A compare value of 0 holds the up-count mode 00 output at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable; also gates match events |
| count_down | input | 1 | 1 selects down counting |
| period | input | 16 | Last count value of a cycle |
| match_vals | input | 64 | Compare value of channel n at bits 16n+15:16n |
| act_cfg | input | 8 | Match action of channel n at bits 2n+1:2n |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data, key in bits 31:24 |
| cfg_rdata | output | 32 | Control word read-back |
| gpio_i | input | 4 | General-purpose values for the pins |
| count_o | output | 16 | Current count |
| pin_o | output | 4 | Pin levels |

## Verification
The hardest situations to reach are the edges of the compare range: a compare value of zero, one equal to the period, and one beyond it. The down-count direction adds its reload step, where a below-or-equal test replaces the strict one. To reach these, a table of configurations gives the four channels compare values one apart. A single run therefore places channels at, just under and past the period at the same time. Each configuration is walked through two full cycles in each direction, including a zero-length period. Directed sequences then chain set, clear and toggle actions, and send control writes with a wrong key and with reserved bits set.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

    parameter int CNT_W  = 16;
    parameter int NUM_CH = 4;
    parameter int WORD_W = 32;

    localparam int          KEY_W    = 8;
    localparam int          KEY_LSB  = WORD_W - KEY_W;
    localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;
    localparam int          SEL_LSB  = 20;
    localparam int          MODE_LSB = 4;
    localparam int          PWM_LSB  = 0;
    localparam int          MODE_W   = 2 * NUM_CH;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_FLIP = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        OM_LOW_BELOW  = 2'b00,
        OM_HIGH_BELOW = 2'b01,
        OM_FORCE0     = 2'b10,
        OM_FORCE1     = 2'b11
    } omode_e;

    typedef struct packed {
        logic [NUM_CH-1:0]      pin_sel;
        logic [NUM_CH-1:0][1:0] mode;
        logic [NUM_CH-1:0]      pwm_on;
    } ctrl_t;

    function automatic logic apply_act(act_e a, logic cur);
        case (a)
            ACT_CLR:  return 1'b0;
            ACT_SET:  return 1'b1;
            ACT_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

    function automatic logic pwm_level(omode_e m, logic down,
                                       logic [CNT_W-1:0] c,
                                       logic [CNT_W-1:0] t);
        logic under;
        under = down ? (c <= t) : (c < t);
        case (m)
            OM_LOW_BELOW:  return ~under;
            OM_HIGH_BELOW: return under;
            OM_FORCE0:     return 1'b0;
            default:       return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tpw_counter.sv
module tpw_counter
    import tpw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             down,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt
);

    logic at_top;
    logic at_bottom;

    // a shrunk period must not let the count run through the full range
    assign at_top    = (cnt >= period);
    assign at_bottom = (cnt == '0) || (cnt > period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (run) begin
            if (down) begin
                cnt <= at_bottom ? period : cnt - 1'b1;
            end else begin
                cnt <= at_top ? '0 : cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tpw_ctrl_reg.sv
module tpw_ctrl_reg
    import tpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [WORD_W-1:0] rdata
);

    logic key_ok;

    assign key_ok = (wdata[KEY_LSB +: KEY_W] == WR_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && key_ok) begin
            ctrl.pin_sel <= wdata[SEL_LSB +: NUM_CH];
            ctrl.mode    <= wdata[MODE_LSB +: MODE_W];
            ctrl.pwm_on  <= wdata[PWM_LSB +: NUM_CH];
        end
    end

    // key and reserved bits are left at zero
    always_comb begin
        rdata                      = '0;
        rdata[SEL_LSB +: NUM_CH]   = ctrl.pin_sel;
        rdata[MODE_LSB +: MODE_W]  = ctrl.mode;
        rdata[PWM_LSB +: NUM_CH]   = ctrl.pwm_on;
    end

endmodule

// File: rtl/tpw_channel.sv
module tpw_channel
    import tpw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             down,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] match,
    input  act_e             act,
    input  omode_e           mode,
    input  logic             pwm_on,
    input  logic             pin_sel,
    input  logic             gpio,
    output logic             pin
);

    logic hit;
    logic act_q;
    logic chan;

    assign hit = run && (cnt == match);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
        end else if (hit) begin
            act_q <= apply_act(act, act_q);
        end
    end

    always_comb begin
        chan = pwm_on ? pwm_level(mode, down, cnt, match) : act_q;
        pin  = pin_sel ? chan : gpio;
    end

endmodule

// File: rtl/tpw_unit.sv
module tpw_unit
    import tpw_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    count_down,
    input  logic [CNT_W-1:0]        period,
    input  logic [NUM_CH*CNT_W-1:0] match_vals,
    input  logic [2*NUM_CH-1:0]     act_cfg,
    input  logic                    cfg_wr_en,
    input  logic [WORD_W-1:0]       cfg_wdata,
    output logic [WORD_W-1:0]       cfg_rdata,
    input  logic [NUM_CH-1:0]       gpio_i,
    output logic [CNT_W-1:0]        count_o,
    output logic [NUM_CH-1:0]       pin_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] cnt;

    tpw_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .down   (count_down),
        .period (period),
        .cnt    (cnt)
    );

    tpw_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .rdata (cfg_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tpw_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .run     (run),
            .down    (count_down),
            .cnt     (cnt),
            .match   (match_vals[g*CNT_W +: CNT_W]),
            .act     (act_e'(act_cfg[2*g +: 2])),
            .mode    (omode_e'(ctrl.mode[g])),
            .pwm_on  (ctrl.pwm_on[g]),
            .pin_sel (ctrl.pin_sel[g]),
            .gpio    (gpio_i[g]),
            .pin     (pin_o[g])
        );
    end

    assign count_o = cnt;

endmodule

// File: rtl/tpw_unit_chk.sv
module tpw_unit_chk
    import tpw_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    run,
    input logic                    count_down,
    input logic [CNT_W-1:0]        period,
    input logic [NUM_CH*CNT_W-1:0] match_vals,
    input logic [2*NUM_CH-1:0]     act_cfg,
    input logic                    cfg_wr_en,
    input logic [WORD_W-1:0]       cfg_wdata,
    input logic [WORD_W-1:0]       cfg_rdata,
    input logic [NUM_CH-1:0]       gpio_i,
    input logic [CNT_W-1:0]        count_o,
    input logic [NUM_CH-1:0]       pin_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count_o == '0) && (cfg_rdata == '0));

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !count_down && count_o >= period) |=> count_o == '0);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count_o));

    assert_down_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (run && count_down && count_o == '0) |=> count_o == $past(period));

    assert_key_guard_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wdata[KEY_LSB +: KEY_W] != WR_KEY) |=> $stable(cfg_rdata));

    assert_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[KEY_LSB +: KEY_W] == '0) && (cfg_rdata[19:12] == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pin
        assert_gpio_path_R6: assert property (@(posedge clk) disable iff (rst)
            !cfg_rdata[SEL_LSB + g] |-> pin_o[g] == gpio_i[g]);

        assert_forced_high_R9: assert property (@(posedge clk) disable iff (rst)
            (cfg_rdata[SEL_LSB + g] && cfg_rdata[PWM_LSB + g] &&
             cfg_rdata[MODE_LSB + 2*g +: 2] == 2'b11) |-> pin_o[g]);
    end

endmodule

bind tpw_unit tpw_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .count_down (count_down),
    .period     (period),
    .match_vals (match_vals),
    .act_cfg    (act_cfg),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .gpio_i     (gpio_i),
    .count_o    (count_o),
    .pin_o      (pin_o)
);

// File: tb/tpw_unit_test.sv
module tpw_unit_test;

    localparam int NCH = 4;
    localparam int CW  = 16;

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] mt;
        logic        dn;
        logic [1:0]  md;
        logic        pw;
        logic [1:0]  ac;
        logic [3:0]  ps;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{16'd5, 16'd2, 1'b0, 2'd0, 1'b1, 2'd0, 4'hF},
        '{16'd5, 16'd2, 1'b1, 2'd0, 1'b1, 2'd0, 4'hF},
        '{16'd5, 16'd0, 1'b0, 2'd1, 1'b1, 2'd0, 4'hF},
        '{16'd4, 16'd3, 1'b1, 2'd1, 1'b1, 2'd0, 4'hF},
        '{16'd5, 16'd5, 1'b0, 2'd0, 1'b1, 2'd0, 4'hF},
        '{16'd5, 16'd5, 1'b1, 2'd1, 1'b1, 2'd0, 4'hF},
        '{16'd6, 16'd1, 1'b0, 2'd2, 1'b1, 2'd0, 4'hF},
        '{16'd6, 16'd1, 1'b1, 2'd3, 1'b1, 2'd0, 4'hF},
        '{16'd5, 16'd2, 1'b0, 2'd0, 1'b0, 2'd3, 4'hF},
        '{16'd5, 16'd0, 1'b1, 2'd0, 1'b0, 2'd2, 4'hF},
        '{16'd4, 16'd3, 1'b0, 2'd0, 1'b0, 2'd0, 4'hF},
        '{16'd5, 16'd2, 1'b0, 2'd0, 1'b1, 2'd0, 4'h5},
        '{16'd0, 16'd0, 1'b0, 2'd0, 1'b1, 2'd0, 4'hF}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b0;
    logic            run = 1'b0;
    logic            count_down = 1'b0;
    logic [CW-1:0]   period = '0;
    logic [NCH*CW-1:0] match_vals = '0;
    logic [2*NCH-1:0] act_cfg = '0;
    logic            cfg_wr_en = 1'b0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic [NCH-1:0]  gpio_i = 4'b1010;
    logic [CW-1:0]   count_o;
    logic [NCH-1:0]  pin_o;

    int checks = 0;
    int fails  = 0;
    int mcnt   = 0;
    logic [NCH-1:0] mact = '0;
    logic [1:0] cur_md = 2'd0;
    logic [NCH-1:0] cur_pw = '0;
    logic [NCH-1:0] cur_ps = '0;

    always #10 clk = ~clk;

    tpw_unit uut (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .count_down (count_down),
        .period     (period),
        .match_vals (match_vals),
        .act_cfg    (act_cfg),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .gpio_i     (gpio_i),
        .count_o    (count_o),
        .pin_o      (pin_o)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic act_ref(logic [1:0] a, logic cur);
        if (a == 2'b01) return 1'b0;
        if (a == 2'b10) return 1'b1;
        if (a == 2'b11) return ~cur;
        return cur;
    endfunction

    function automatic logic lvl_ref(logic [1:0] md, logic dn, int c, int t);
        logic under;
        if (md == 2'd2) return 1'b0;
        if (md == 2'd3) return 1'b1;
        under = dn ? (c <= t) : (c < t);
        return (md == 2'd0) ? ~under : under;
    endfunction

    function automatic logic [31:0] mk_cfg(logic [7:0] key, logic [3:0] ps,
                                           logic [1:0] md, logic [3:0] pw);
        return {key, ps, 8'h00, md, md, md, md, pw};
    endfunction

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            mcnt = 0;
            mact = '0;
        end else if (run) begin
            for (int n = 0; n < NCH; n++) begin
                if (mcnt == int'(match_vals[CW*n +: CW]))
                    mact[n] = act_ref(act_cfg[2*n +: 2], mact[n]);
            end
            if (count_down)
                mcnt = (mcnt == 0 || mcnt > int'(period)) ? int'(period) : mcnt - 1;
            else
                mcnt = (mcnt >= int'(period)) ? 0 : mcnt + 1;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic wr_cfg(input logic [31:0] d);
        cfg_wr_en = 1'b1;
        cfg_wdata = d;
        tick();
        cfg_wr_en = 1'b0;
        if (d[31:24] == 8'h5A) begin
            cur_ps = d[23:20];
            cur_md = d[5:4];
            cur_pw = d[3:0];
        end
    endtask

    task automatic run_cycles(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            logic [NCH-1:0] exp_pin;
            for (int c = 0; c < NCH; c++) begin
                logic lv;
                lv = cur_pw[c] ? lvl_ref(cur_md, count_down, mcnt, int'(match_vals[CW*c +: CW]))
                               : mact[c];
                exp_pin[c] = cur_ps[c] ? lv : gpio_i[c];
            end
            chk(count_o == CW'(mcnt), count_down ? "R3 count" : "R2 count", count_o, mcnt);
            chk(pin_o == exp_pin, tag, pin_o, exp_pin);
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        act_cfg = 8'hFF;
        do_reset();
        chk(count_o == '0, "R1 count", count_o, 0);
        chk(cfg_rdata == '0, "R1 cfg", cfg_rdata, 0);
        chk(pin_o == gpio_i, "R1 pins", pin_o, gpio_i);

        // table of configurations
        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            string tag;
            t = VECS[v];
            run = 1'b0;
            do_reset();
            period     = t.per;
            count_down = t.dn;
            act_cfg    = {t.ac, t.ac, t.ac, t.ac};
            for (int c = 0; c < NCH; c++) match_vals[CW*c +: CW] = t.mt + 16'(c);
            wr_cfg(mk_cfg(8'h5A, t.ps, t.md, {4{t.pw}}));
            if (t.ps != 4'hF)      tag = "R6";
            else if (!t.pw)        tag = "R10";
            else if (t.md >= 2'd2) tag = "R9";
            else if (t.md == 2'd1) tag = "R8";
            else                   tag = "R7";
            if (int'(t.mt) + NCH - 1 > int'(t.per) || t.mt == 16'd0) tag = {tag, "+R11"};
            run = 1'b1;
            run_cycles(2 * (int'(t.per) + 1) + 2, tag);
        end

        // R10: set then clear chained across cycles
        run = 1'b0;
        do_reset();
        period = 16'd5;
        count_down = 1'b0;
        match_vals = {16'd2, 16'd2, 16'd2, 16'd2};
        act_cfg = 8'hAA;
        wr_cfg(mk_cfg(8'h5A, 4'hF, 2'd0, 4'h0));
        run = 1'b1;
        run_cycles(7, "R10 set");
        chk(pin_o == 4'hF, "R10 set level", pin_o, 4'hF);
        act_cfg = 8'h55;
        run_cycles(7, "R10 clear");
        chk(pin_o == 4'h0, "R10 clear level", pin_o, 4'h0);

        // R2: hold while run is low
        run = 1'b0;
        run_cycles(3, "R2 hold");

        // R4: wrong keys leave everything unchanged
        wr_cfg(mk_cfg(8'h5A, 4'hF, 2'd1, 4'hF));
        chk(cfg_rdata == mk_cfg(8'h00, 4'hF, 2'd1, 4'hF), "R4 good key", cfg_rdata,
            mk_cfg(8'h00, 4'hF, 2'd1, 4'hF));
        wr_cfg(mk_cfg(8'hA5, 4'h0, 2'd3, 4'h0));
        chk(cfg_rdata == mk_cfg(8'h00, 4'hF, 2'd1, 4'hF), "R4 bad key A5", cfg_rdata,
            mk_cfg(8'h00, 4'hF, 2'd1, 4'hF));
        wr_cfg(mk_cfg(8'h5B, 4'h3, 2'd2, 4'h1));
        chk(cfg_rdata == mk_cfg(8'h00, 4'hF, 2'd1, 4'hF), "R4 bad key 5B", cfg_rdata,
            mk_cfg(8'h00, 4'hF, 2'd1, 4'hF));
        run = 1'b1;
        run_cycles(6, "R4 pins");

        // R5: field placement and reserved bits
        wr_cfg({8'h5A, 4'h3, 8'hFF, 8'b1110_0100, 4'h9});
        chk(cfg_rdata == {8'h00, 4'h3, 8'h00, 8'b1110_0100, 4'h9}, "R5 layout", cfg_rdata,
            {8'h00, 4'h3, 8'h00, 8'b1110_0100, 4'h9});

        // R1: reset in the middle of activity
        rst = 1'b1;
        tick();
        rst = 1'b0;
        run = 1'b0;
        chk(count_o == '0, "R1 mid count", count_o, 0);
        chk(cfg_rdata == '0, "R1 mid cfg", cfg_rdata, 0);
        chk(pin_o == gpio_i, "R1 mid pins", pin_o, gpio_i);

        summary();
        $finish;
    end

endmodule